// File: doc/BRIEF.md
# Single-Port Synchronous Block Memory with Selectable Write Read-Back

This block is a 9216-bit synchronous single-port memory. A parameter picks either 1024 words of 9 bits or 512 words of 18 bits. The address, the write data, the write enable, the select and the clock enable are all taken on the rising clock edge. Read data lands in a data latch on that same edge. An optional output register follows the latch. It has its own load enable and is cleared by the synchronous reset.

A parameter decides what the latch shows when a write cycle happens. It can keep its previous value, show the word as it is stored after the write, or show the word that the write replaced. In the 18-bit shape, two byte enables each gate one 9-bit half of the word. By default every word starts at zero. A base and a step parameter can instead fill each word with a linear pattern of its address.

Top module: `sprm_wrap`

## Requirements
- R1: A read cycle (ce=1, cs=1, we=0) on a rising edge loads the data latch with the word at the given address, so with no output register the word is on `rdata` one edge after the request.
- R2: With the output register present (OUT_REG=1), `rdata` takes the data latch value only on an edge where oce=1 and holds otherwise, so a read costs two edges when oce is high.
- R3: On any edge where ce=0 or cs=0 nothing is written and the data latch keeps its value, whatever we, addr and wdata are.
- R4: In normal mode (MODE=WM_NORMAL) a write cycle changes the array but leaves the data latch unchanged.
- R5: In write-through mode (MODE=WM_THROUGH) a write cycle loads the data latch with the addressed word as it is stored after the write.
- R6: In read-before-write mode (MODE=WM_READ_FIRST) a write cycle loads the data latch with the addressed word as it was before the write.
- R7: In the 18-bit shape, ben[0] gates bits 8:0 and ben[1] gates bits 17:9 of a write; a disabled half keeps its old contents. In the 9-bit shape ben is ignored and every write stores the whole word.
- R8: rst is synchronous and active high. On an edge with rst=1 the data latch and the output register become zero, and the array contents are not changed.
- R9: After start-up, the word at address a holds (INIT_BASE + a*INIT_STEP) truncated to the word width; with the default parameters every word is zero.
- R10: WIDE=1 gives 512 words of 18 bits with a 9-bit address; WIDE=0 gives 1024 words of 9 bits with a 10-bit address; every address up to the top one is usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear of the data latch and output register, active high |
| ce | input | 1 | Clock enable for the array and data latch, active high |
| oce | input | 1 | Load enable of the output register, active high |
| cs | input | 1 | Select, active high |
| we | input | 1 | Write enable, active high |
| addr | input | 9 (WIDE=1) or 10 | Word address |
| wdata | input | 18 (WIDE=1) or 9 | Write data |
| ben | input | 2 | Half-word write enables, used in the 18-bit shape |
| rdata | output | 18 (WIDE=1) or 9 | Read data |

## Verification
The data latch result of a request is due on the first rising edge after the request is presented. The output register result is due one edge later, and only if oce is high on that second edge. The bench applies each request on a falling edge and lets one rising edge pass. It compares all outputs on the next falling edge against a model that it updates as of that rising edge. The model keeps the previous latch value so that the one-edge lag of the output register is reproduced exactly. Three instances share every stimulus: normal mode with the output register, write-through in the 18-bit shape, and read-before-write in the 9-bit shape. Each mode is therefore checked on the same edges.

// File: rtl/sprm_pkg.sv
package sprm_pkg;

  typedef enum logic [1:0] {
    WM_NORMAL     = 2'd0,
    WM_THROUGH    = 2'd1,
    WM_READ_FIRST = 2'd2
  } wmode_e;

  localparam int TOTAL_BITS = 9216;
  localparam int LANE_W     = 9;

  function automatic int word_w(bit wide);
    return wide ? 2 * LANE_W : LANE_W;
  endfunction

  function automatic int word_cnt(bit wide);
    return TOTAL_BITS / word_w(wide);
  endfunction

  function automatic int adr_w(bit wide);
    return $clog2(word_cnt(wide));
  endfunction

  function automatic int lane_cnt(bit wide);
    return word_w(wide) / LANE_W;
  endfunction

  // start-up contents: base + idx*step, cut to w bits
  function automatic logic [17:0] seed_word(int base, int step, int idx, int w);
    logic [63:0] v;
    logic [17:0] m;
    v = 64'(base) + 64'(idx) * 64'(step);
    m = (18'd1 << w) - 18'd1;
    return v[17:0] & m;
  endfunction

endpackage

// File: rtl/sprm_ctl.sv
module sprm_ctl #(
  parameter int LANES = 2
) (
  input  logic             ce,
  input  logic             cs,
  input  logic             we,
  input  logic [1:0]       ben,
  output logic             acc_ev,
  output logic             wr_ev,
  output logic             rd_ev,
  output logic [LANES-1:0] lane_we
);

  assign acc_ev = ce & cs;
  assign wr_ev  = acc_ev & we;
  assign rd_ev  = acc_ev & ~we;

  generate
    if (LANES == 2) begin : g_split
      assign lane_we = ben & {2{wr_ev}};
    end else begin : g_whole
      assign lane_we = {LANES{wr_ev}};
    end
  endgenerate

endmodule

// File: rtl/sprm_array.sv
module sprm_array #(
  parameter bit WIDE      = 1'b1,
  parameter int INIT_BASE = 0,
  parameter int INIT_STEP = 0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [sprm_pkg::adr_w(WIDE)-1:0]    addr,
  input  logic [sprm_pkg::word_w(WIDE)-1:0]   wdata,
  input  logic [sprm_pkg::lane_cnt(WIDE)-1:0] lane_we,
  output logic [sprm_pkg::word_w(WIDE)-1:0]   old_word,
  output logic [sprm_pkg::word_w(WIDE)-1:0]   new_word
);

  localparam int DW    = sprm_pkg::word_w(WIDE);
  localparam int DEPTH = sprm_pkg::word_cnt(WIDE);
  localparam int LANES = sprm_pkg::lane_cnt(WIDE);
  localparam int LW    = sprm_pkg::LANE_W;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(sprm_pkg::seed_word(INIT_BASE, INIT_STEP, i, DW));
    end
  end

  assign old_word = mem[addr];

  always_comb begin
    new_word = old_word;
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) new_word[l*LW +: LW] = wdata[l*LW +: LW];
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) mem[addr][l*LW +: LW] <= wdata[l*LW +: LW];
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
      AST_LANE_KEEP: assert property (@(posedge clk) disable iff (rst)
        !lane_we[g] |=> mem[$past(addr)][g*LW +: LW] == $past(old_word[g*LW +: LW])); // R7
      AST_LANE_LANDS: assert property (@(posedge clk) disable iff (rst)
        lane_we[g] |=> mem[$past(addr)][g*LW +: LW] == $past(wdata[g*LW +: LW])); // R7
    end
  endgenerate

endmodule

// File: rtl/sprm_latch.sv
module sprm_latch #(
  parameter int               DW   = 18,
  parameter sprm_pkg::wmode_e MODE = sprm_pkg::WM_NORMAL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_ev,
  input  logic          wr_ev,
  input  logic          rd_ev,
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] new_word,
  output logic [DW-1:0] q
);

  logic          wr_load;
  logic [DW-1:0] wr_val;

  generate
    if (MODE == sprm_pkg::WM_THROUGH) begin : g_through
      assign wr_load = 1'b1;
      assign wr_val  = new_word;
    end else if (MODE == sprm_pkg::WM_READ_FIRST) begin : g_rfirst
      assign wr_load = 1'b1;
      assign wr_val  = old_word;
    end else begin : g_normal
      assign wr_load = 1'b0;
      assign wr_val  = old_word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (rd_ev) begin
      q <= old_word;
    end else if (wr_ev && wr_load) begin
      q <= wr_val;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_ev |=> $stable(q)); // R3
  AST_READ_DATA: assert property (@(posedge clk) disable iff (rst)
    rd_ev |=> q == $past(old_word)); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> q == '0); // R8

  generate
    if (MODE == sprm_pkg::WM_THROUGH) begin : g_chk_through
      AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
        wr_ev |=> q == $past(new_word)); // R5
    end else if (MODE == sprm_pkg::WM_READ_FIRST) begin : g_chk_rfirst
      AST_WRITE_OLD: assert property (@(posedge clk) disable iff (rst)
        wr_ev |=> q == $past(old_word)); // R6
    end else begin : g_chk_normal
      AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        wr_ev |=> $stable(q)); // R4
    end
  endgenerate

endmodule

// File: rtl/sprm_opipe.sv
module sprm_opipe #(
  parameter int DW      = 18,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          oce,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (oce) q <= d;
      end

      AST_OREG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !oce |=> $stable(q)); // R2
      AST_OREG_LOAD: assert property (@(posedge clk) disable iff (rst)
        oce |=> q == $past(d)); // R2
      AST_OREG_CLEAR: assert property (@(posedge clk)
        rst |=> q == '0); // R8
    end else begin : g_bypass
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/sprm_wrap.sv
module sprm_wrap #(
  parameter bit               WIDE      = 1'b1,
  parameter sprm_pkg::wmode_e MODE      = sprm_pkg::WM_NORMAL,
  parameter bit               OUT_REG   = 1'b1,
  parameter int               INIT_BASE = 0,
  parameter int               INIT_STEP = 0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ce,
  input  logic                              oce,
  input  logic                              cs,
  input  logic                              we,
  input  logic [sprm_pkg::adr_w(WIDE)-1:0]  addr,
  input  logic [sprm_pkg::word_w(WIDE)-1:0] wdata,
  input  logic [1:0]                        ben,
  output logic [sprm_pkg::word_w(WIDE)-1:0] rdata
);

  localparam int DW    = sprm_pkg::word_w(WIDE);
  localparam int LANES = sprm_pkg::lane_cnt(WIDE);

  logic             acc_ev;
  logic             wr_ev;
  logic             rd_ev;
  logic [LANES-1:0] lane_we;
  logic [DW-1:0]    old_word;
  logic [DW-1:0]    new_word;
  logic [DW-1:0]    latch_q;

  sprm_ctl #(.LANES(LANES)) u_ctl (
    .ce      (ce),
    .cs      (cs),
    .we      (we),
    .ben     (ben),
    .acc_ev  (acc_ev),
    .wr_ev   (wr_ev),
    .rd_ev   (rd_ev),
    .lane_we (lane_we)
  );

  sprm_array #(.WIDE(WIDE), .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)) u_array (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wdata    (wdata),
    .lane_we  (lane_we),
    .old_word (old_word),
    .new_word (new_word)
  );

  sprm_latch #(.DW(DW), .MODE(MODE)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .acc_ev   (acc_ev),
    .wr_ev    (wr_ev),
    .rd_ev    (rd_ev),
    .old_word (old_word),
    .new_word (new_word),
    .q        (latch_q)
  );

  sprm_opipe #(.DW(DW), .OUT_REG(OUT_REG)) u_opipe (
    .clk (clk),
    .rst (rst),
    .oce (oce),
    .d   (latch_q),
    .q   (rdata)
  );

endmodule

// File: tb/test_sprm_wrap.sv
module test_sprm_wrap;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0, oce = 1'b0, cs = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [17:0] wdata = '0;
  logic [1:0]  ben = '0;
  logic [17:0] rd_a, rd_b;
  logic [8:0]  rd_c;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  // A: normal, output register, 18-bit, zero fill
  sprm_wrap #(.WIDE(1'b1), .MODE(sprm_pkg::WM_NORMAL), .OUT_REG(1'b1)) i_sprm_wrap (
    .clk(clk), .rst(rst), .ce(ce), .oce(oce), .cs(cs), .we(we),
    .addr(addr[8:0]), .wdata(wdata), .ben(ben), .rdata(rd_a));

  // B: write-through, no output register, 18-bit, fill 0x100 + 3a
  sprm_wrap #(.WIDE(1'b1), .MODE(sprm_pkg::WM_THROUGH), .OUT_REG(1'b0),
              .INIT_BASE(256), .INIT_STEP(3)) i_sprm_wrap_wt (
    .clk(clk), .rst(rst), .ce(ce), .oce(oce), .cs(cs), .we(we),
    .addr(addr[8:0]), .wdata(wdata), .ben(ben), .rdata(rd_b));

  // C: read-before-write, no output register, 9-bit, fill 5 + a
  sprm_wrap #(.WIDE(1'b0), .MODE(sprm_pkg::WM_READ_FIRST), .OUT_REG(1'b0),
              .INIT_BASE(5), .INIT_STEP(1)) i_sprm_wrap_rf (
    .clk(clk), .rst(rst), .ce(ce), .oce(oce), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata[8:0]), .ben(ben), .rdata(rd_c));

  // reference model
  logic [17:0] m_a [512];
  logic [17:0] m_b [512];
  logic [8:0]  m_c [1024];
  logic [17:0] lat_a = '0, out_a = '0, lat_b = '0;
  logic [8:0]  lat_c = '0;

  initial begin
    for (int i = 0; i < 512; i++) begin
      m_a[i] = '0;
      m_b[i] = 18'((256 + 3 * i) % 262144);
    end
    for (int i = 0; i < 1024; i++) m_c[i] = 9'((5 + i) % 512);
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(string tag, string who, logic [17:0] got, logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, who, got, exp);
    end
  endtask

  function automatic logic [17:0] put_halves(logic [17:0] old, logic [17:0] d, logic [1:0] b);
    logic [17:0] r;
    r = old;
    if (b[0]) r[8:0]  = d[8:0];
    if (b[1]) r[17:9] = d[17:9];
    return r;
  endfunction

  // called at a falling edge; applies one request and checks after the next rising edge
  task automatic op(logic i_ce, logic i_cs, logic i_we, logic [9:0] a, logic [17:0] d,
                    logic [1:0] b, logic i_oce, logic i_rst,
                    string tag_a, string tag_b, string tag_c);
    logic        acc;
    logic [17:0] old_a, old_b, new_a, new_b;
    logic [8:0]  old_c;
    ce = i_ce; cs = i_cs; we = i_we; addr = a; wdata = d; ben = b; oce = i_oce; rst = i_rst;
    @(posedge clk);
    acc   = i_ce & i_cs;
    old_a = m_a[a[8:0]];
    old_b = m_b[a[8:0]];
    old_c = m_c[a];
    new_a = put_halves(old_a, d, b);
    new_b = put_halves(old_b, d, b);
    if (i_rst)      out_a = '0;
    else if (i_oce) out_a = lat_a;
    if (i_rst) begin
      lat_a = '0; lat_b = '0; lat_c = '0;
    end else if (acc && !i_we) begin
      lat_a = old_a; lat_b = old_b; lat_c = old_c;
    end else if (acc) begin
      lat_b = new_b;
      lat_c = old_c;
    end
    if (acc && i_we) begin
      m_a[a[8:0]] = new_a;
      m_b[a[8:0]] = new_b;
      m_c[a]      = d[8:0];
    end
    @(negedge clk);
    chk(tag_a, "normal/oreg", rd_a, out_a);
    chk(tag_b, "through",     rd_b, lat_b);
    chk(tag_c, "readfirst",   {9'd0, rd_c}, {9'd0, lat_c});
  endtask

  task automatic t_reset_state();
    op(0, 0, 0, 10'd0, 18'd0, 2'b00, 0, 1, "R8", "R8", "R8");
    op(0, 0, 0, 10'd0, 18'd0, 2'b00, 1, 1, "R8", "R8", "R8");
  endtask

  task automatic t_init_read();
    op(1, 1, 0, 10'd0,   18'd0, 2'b00, 1, 0, "R9", "R9", "R9");
    op(1, 1, 0, 10'd7,   18'd0, 2'b00, 1, 0, "R9", "R1", "R1");
    op(1, 1, 0, 10'h3FF, 18'd0, 2'b00, 1, 0, "R10", "R10", "R10");
    op(0, 0, 0, 10'd0,   18'd0, 2'b00, 1, 0, "R2", "R3", "R3");
  endtask

  task automatic t_write_modes();
    op(1, 1, 0, 10'd5,   18'd0,     2'b00, 1, 0, "R1", "R1", "R1");
    op(1, 1, 1, 10'd7,   18'h2AB5,  2'b11, 1, 0, "R4", "R5", "R6");
    op(0, 0, 0, 10'd0,   18'd0,     2'b00, 1, 0, "R4", "R3", "R3");
    op(1, 1, 0, 10'd7,   18'd0,     2'b00, 1, 0, "R1", "R1", "R1");
    op(1, 1, 1, 10'd7,   18'h1234A, 2'b11, 1, 0, "R4", "R5", "R6");
    op(0, 0, 0, 10'd0,   18'd0,     2'b00, 1, 0, "R4", "R3", "R3");
  endtask

  task automatic t_oce_gate();
    op(1, 1, 0, 10'd9, 18'd0, 2'b00, 0, 0, "R2", "R1", "R1");
    op(0, 0, 0, 10'd0, 18'd0, 2'b00, 0, 0, "R2", "R3", "R3");
    op(0, 0, 0, 10'd0, 18'd0, 2'b00, 1, 0, "R2", "R3", "R3");
    op(1, 1, 0, 10'd7, 18'd0, 2'b00, 1, 0, "R2", "R1", "R1");
    op(0, 0, 0, 10'd0, 18'd0, 2'b00, 1, 0, "R2", "R3", "R3");
  endtask

  task automatic t_idle_block();
    op(0, 1, 1, 10'd20, 18'h3FFFF, 2'b11, 1, 0, "R3", "R3", "R3");
    op(1, 0, 1, 10'd20, 18'h3FFFF, 2'b11, 1, 0, "R3", "R3", "R3");
    op(1, 1, 0, 10'd20, 18'h3FFFF, 2'b11, 1, 0, "R3", "R3", "R3");
    op(0, 0, 0, 10'd0,  18'd0,     2'b00, 1, 0, "R3", "R3", "R3");
  endtask

  task automatic t_byte_lanes();
    op(1, 1, 1, 10'd30, 18'h00000, 2'b11, 1, 0, "R7", "R7", "R7");
    op(1, 1, 1, 10'd30, 18'h3FFFF, 2'b01, 1, 0, "R7", "R7", "R7");
    op(1, 1, 0, 10'd30, 18'd0,     2'b00, 1, 0, "R7", "R7", "R7");
    op(1, 1, 1, 10'd30, 18'h15555, 2'b10, 1, 0, "R7", "R7", "R7");
    op(1, 1, 0, 10'd30, 18'd0,     2'b00, 1, 0, "R7", "R7", "R7");
    op(1, 1, 1, 10'd31, 18'h001AA, 2'b00, 1, 0, "R7", "R7", "R7");
    op(1, 1, 0, 10'd31, 18'd0,     2'b00, 1, 0, "R7", "R7", "R7");
    op(0, 0, 0, 10'd0,  18'd0,     2'b00, 1, 0, "R7", "R7", "R7");
  endtask

  task automatic t_reset_mid();
    op(1, 1, 1, 10'd40, 18'h12345, 2'b11, 1, 0, "R4", "R5", "R6");
    op(1, 1, 0, 10'd40, 18'd0,     2'b00, 1, 1, "R8", "R8", "R8");
    op(1, 1, 0, 10'd40, 18'd0,     2'b00, 1, 0, "R8", "R8", "R8");
    op(0, 0, 0, 10'd0,  18'd0,     2'b00, 1, 0, "R8", "R8", "R8");
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 6; i++) begin
      op(1, 1, 1, 10'((i * 211) % 1024), 18'((i * 40503 + 77) % 262144), 2'b11, 1, 0,
         "R10", "R10", "R10");
    end
    for (int i = 0; i < 6; i++) begin
      op(1, 1, 0, 10'((i * 211) % 1024), 18'd0, 2'b00, 1, 0, "R10", "R10", "R10");
    end
    op(1, 1, 1, 10'h3FF, 18'h2F0F0, 2'b11, 1, 0, "R10", "R10", "R10");
    op(1, 1, 0, 10'h3FF, 18'd0,     2'b00, 1, 0, "R10", "R10", "R10");
    op(0, 0, 0, 10'd0,   18'd0,     2'b00, 1, 0, "R10", "R10", "R10");
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_init_read();
    t_write_modes();
    t_oce_gate();
    t_idle_block();
    t_byte_lanes();
    t_reset_mid();
    t_sweep();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

endmodule